// File: doc/BRIEF.md
# IPv4/TCP Header Field Extractor

This block sits at the head of a packet inspection path. It receives a packet as a stream of 32-bit words, one word per clock when its valid input is high. It walks a fixed sequence of word positions that covers an IPv4 header followed by a TCP header. A first word whose version nibble is not 4 is dropped. A packet whose protocol byte is not TCP is abandoned early. Along the way the block latches the header fields that a rule stage needs.

Once the header words have been consumed, the block computes the payload byte count from the IP total length and the two header lengths. It then raises a payload-qualify output for exactly as many words as that count needs. The output is the upstream valid gated by the payload phase, so a downstream signature checker can take the same word bus and treat only qualified words as payload. Each fully parsed TCP packet advances a packet counter, which serves as the packet number for results.

Top module: `hdrx_top`

## Requirements
- R1: After reset, every field output and `pkt_num` read zero and `pay_valid` is low.
- R2: In the first-word position, a valid word whose bits 31:28 are not 4 is dropped. The parser stays at the first-word position and no output changes.
- R3: A valid first word with bits 31:28 equal to 4 loads `ip_hdr_words` from bits 27:24 and `ip_total_len` from bits 15:0. These values are visible from the next cycle.
- R4: The second word loads `ip_ident` from bits 31:16.
- R5: The third word is accepted only when bits 23:16 equal 0x06. Otherwise the parser returns to the first-word position, and `pkt_num` is unchanged.
- R6: The fifth word (index 4) loads `ip_dst` with all 32 bits.
- R7: The seventh word (index 6) loads `tcp_src_port` from bits 31:16 and `tcp_dst_port` from bits 15:0.
- R8: The tenth word (index 9) loads `tcp_doff` from bits 31:28. In the same cycle it sets `pay_bytes` to `ip_total_len` − 4·`ip_hdr_words` − 4·`tcp_doff`, clamped to zero when the result would be negative.
- R9: Words at indices 3, 5, 7, 8 and 10 are consumed without changing any output.
- R10: After word index 10, `pay_valid` equals `in_valid` for the next ceil(`pay_bytes`/4) valid words. It is low at all other times, in the same cycle as the word.
- R11: A cycle with `in_valid` low consumes nothing. Parser position and all outputs hold, and `pay_valid` is low.
- R12: `pkt_num` increments by one, wrapping at 2^PKT_W. This happens one cycle after the last payload word of a TCP packet, or after word index 10 when `pay_bytes` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word on `in_data` is valid this cycle |
| in_data | input | 32 | Packet word |
| pay_valid | output | 1 | Current word is payload (gated by `in_valid`) |
| ip_hdr_words | output | 4 | IP header length in 32-bit words |
| ip_total_len | output | LEN_W | IP total length in bytes |
| ip_ident | output | 16 | IP identification |
| ip_dst | output | 32 | IP destination address |
| tcp_src_port | output | 16 | TCP source port |
| tcp_dst_port | output | 16 | TCP destination port |
| tcp_doff | output | 4 | TCP data offset in 32-bit words |
| pay_bytes | output | LEN_W | Computed payload length in bytes |
| pkt_num | output | PKT_W | Count of completed TCP packets |

## Verification
Each captured field is due one cycle after the edge that consumes its word. `pay_valid` is due in the same cycle as the word it qualifies, and `pkt_num` is due one cycle after the final payload word. The bench drives each word on the falling edge and compares every output shortly after. It compares against a behavioural word-index model before the model advances on that word, so registered outputs are checked against the state left by earlier words. `pay_valid` is checked against the current word. The stimulus includes stalls with IPv4-looking data, rejected versions and protocols, zero and negative payload lengths, an exact multiple of four, and enough packets to wrap the counter.

// File: rtl/hdrx_pkg.sv
package hdrx_pkg;
  localparam int WORD_W   = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam logic [3:0] IPV4_VER  = 4'd4;
  localparam logic [7:0] PROTO_TCP = 8'h06;

  typedef enum logic [3:0] {
    ST_VER       = 4'd0,
    ST_IDENT     = 4'd1,
    ST_PROTO     = 4'd2,
    ST_SKIP_SRC  = 4'd3,
    ST_DST       = 4'd4,
    ST_SKIP_OPT  = 4'd5,
    ST_PORTS     = 4'd6,
    ST_SKIP_SEQ  = 4'd7,
    ST_SKIP_ACK  = 4'd8,
    ST_DOFF      = 4'd9,
    ST_SKIP_TOPT = 4'd10,
    ST_PAY       = 4'd11
  } st_e;
endpackage

// File: rtl/hdrx_seq.sv
module hdrx_seq
  import hdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  logic              zero_pay,
  input  logic              last_pay,
  output st_e               state
);
  st_e nxt;

  always_comb begin
    nxt = state;
    if (in_valid) begin
      unique case (state)
        ST_VER:       nxt = (in_data[31:28] == IPV4_VER) ? ST_IDENT : ST_VER;
        ST_IDENT:     nxt = ST_PROTO;
        ST_PROTO:     nxt = (in_data[23:16] == PROTO_TCP) ? ST_SKIP_SRC : ST_VER;
        ST_SKIP_SRC:  nxt = ST_DST;
        ST_DST:       nxt = ST_SKIP_OPT;
        ST_SKIP_OPT:  nxt = ST_PORTS;
        ST_PORTS:     nxt = ST_SKIP_SEQ;
        ST_SKIP_SEQ:  nxt = ST_SKIP_ACK;
        ST_SKIP_ACK:  nxt = ST_DOFF;
        ST_DOFF:      nxt = ST_SKIP_TOPT;
        ST_SKIP_TOPT: nxt = zero_pay ? ST_VER : ST_PAY;
        ST_PAY:       nxt = last_pay ? ST_VER : ST_PAY;
        default:      nxt = ST_VER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_VER;
    else        state <= nxt;
  end
endmodule

// File: rtl/hdrx_capture.sv
module hdrx_capture
  import hdrx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  input  st_e               state,
  output logic [3:0]        ip_hdr_words,
  output logic [LEN_W-1:0]  ip_total_len,
  output logic [15:0]       ip_ident,
  output logic [31:0]       ip_dst,
  output logic [15:0]       tcp_src_port,
  output logic [15:0]       tcp_dst_port,
  output logic [3:0]        tcp_doff,
  output logic [LEN_W-1:0]  pay_bytes,
  output logic              zero_pay
);
  localparam int DW = LEN_W + 1;

  logic en_ver, en_ident, en_dst, en_ports, en_doff;
  logic [DW-1:0] diff;

  assign en_ver   = in_valid && (state == ST_VER) && (in_data[31:28] == IPV4_VER);
  assign en_ident = in_valid && (state == ST_IDENT);
  assign en_dst   = in_valid && (state == ST_DST);
  assign en_ports = in_valid && (state == ST_PORTS);
  assign en_doff  = in_valid && (state == ST_DOFF);

  always_comb begin
    diff = {1'b0, ip_total_len}
         - DW'({ip_hdr_words, 2'b00})
         - DW'({in_data[31:28], 2'b00});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_hdr_words <= '0;
      ip_total_len <= '0;
    end else if (en_ver) begin
      ip_hdr_words <= in_data[27:24];
      ip_total_len <= LEN_W'(in_data[15:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ip_ident <= '0;
    else if (en_ident) ip_ident <= in_data[31:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ip_dst <= '0;
    else if (en_dst) ip_dst <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcp_src_port <= '0;
      tcp_dst_port <= '0;
    end else if (en_ports) begin
      tcp_src_port <= in_data[31:16];
      tcp_dst_port <= in_data[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcp_doff  <= '0;
      pay_bytes <= '0;
    end else if (en_doff) begin
      tcp_doff  <= in_data[31:28];
      pay_bytes <= diff[LEN_W] ? '0 : diff[LEN_W-1:0];
    end
  end

  assign zero_pay = (pay_bytes == '0);
endmodule

// File: rtl/hdrx_pay_track.sv
module hdrx_pay_track
  import hdrx_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int PKT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  st_e              state,
  input  logic [LEN_W-1:0] pay_bytes,
  input  logic             zero_pay,
  output logic             last_pay,
  output logic [PKT_W-1:0] pkt_num
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(WORD_BYTES);

  logic [LEN_W-1:0] remain;
  logic load, consume, done;

  assign load     = in_valid && (state == ST_SKIP_TOPT);
  assign consume  = in_valid && (state == ST_PAY);
  assign last_pay = (remain <= STEP);
  assign done     = (load && zero_pay) || (consume && last_pay);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       remain <= '0;
    else if (load)    remain <= pay_bytes;
    else if (consume) remain <= remain - STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pkt_num <= '0;
    else if (done) pkt_num <= pkt_num + 1'b1;
  end
endmodule

// File: rtl/hdrx_top.sv
module hdrx_top
  import hdrx_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int PKT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             pay_valid,
  output logic [3:0]       ip_hdr_words,
  output logic [LEN_W-1:0] ip_total_len,
  output logic [15:0]      ip_ident,
  output logic [31:0]      ip_dst,
  output logic [15:0]      tcp_src_port,
  output logic [15:0]      tcp_dst_port,
  output logic [3:0]       tcp_doff,
  output logic [LEN_W-1:0] pay_bytes,
  output logic [PKT_W-1:0] pkt_num
);
  logic [1:0] rsync;
  logic       rst_core_n;
  st_e        state;
  logic       zero_pay, last_pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_core_n = rsync[1];

  hdrx_seq i_seq (
    .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_data(in_data),
    .zero_pay(zero_pay), .last_pay(last_pay), .state(state)
  );

  hdrx_capture #(.LEN_W(LEN_W)) i_cap (
    .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_data(in_data),
    .state(state), .ip_hdr_words(ip_hdr_words), .ip_total_len(ip_total_len),
    .ip_ident(ip_ident), .ip_dst(ip_dst), .tcp_src_port(tcp_src_port),
    .tcp_dst_port(tcp_dst_port), .tcp_doff(tcp_doff), .pay_bytes(pay_bytes),
    .zero_pay(zero_pay)
  );

  hdrx_pay_track #(.LEN_W(LEN_W), .PKT_W(PKT_W)) i_trk (
    .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .state(state),
    .pay_bytes(pay_bytes), .zero_pay(zero_pay), .last_pay(last_pay),
    .pkt_num(pkt_num)
  );

  assign pay_valid = (state == ST_PAY) && in_valid;
endmodule

// File: rtl/hdrx_chk.sv
module hdrx_chk
  import hdrx_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int PKT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [31:0]      in_data,
  input st_e              state,
  input logic             pay_valid,
  input logic [3:0]       ip_hdr_words,
  input logic [LEN_W-1:0] ip_total_len,
  input logic [31:0]      ip_dst,
  input logic [LEN_W-1:0] pay_bytes,
  input logic [PKT_W-1:0] pkt_num
);
  assert_payv_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> in_valid);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pkt_num) && $stable(ip_dst) && $stable(ip_total_len)
                   && $stable(pay_bytes) && $stable(ip_hdr_words)));

  assert_bad_ver_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && state == ST_VER && in_data[31:28] != IPV4_VER)
      |=> ($stable(ip_total_len) && $stable(ip_hdr_words) && !pay_valid));

  assert_pkt_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_num != $past(pkt_num)) |-> (pkt_num == PKT_W'($past(pkt_num) + 1'b1)));

  assert_pkt_end_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_num != $past(pkt_num)) |-> !pay_valid);
endmodule

bind hdrx_top hdrx_chk #(.LEN_W(LEN_W), .PKT_W(PKT_W)) i_chk (
  .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_data(in_data),
  .state(state), .pay_valid(pay_valid), .ip_hdr_words(ip_hdr_words),
  .ip_total_len(ip_total_len), .ip_dst(ip_dst), .pay_bytes(pay_bytes),
  .pkt_num(pkt_num)
);

// File: tb/test_hdrx_top.sv
module test_hdrx_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;
  localparam int PKT_W = 8;

  logic clk, rst_n, in_valid;
  logic [31:0] in_data;
  logic pay_valid;
  logic [3:0] ip_hdr_words, tcp_doff;
  logic [LEN_W-1:0] ip_total_len, pay_bytes;
  logic [15:0] ip_ident, tcp_src_port, tcp_dst_port;
  logic [31:0] ip_dst;
  logic [PKT_W-1:0] pkt_num;

  int n_checks = 0;
  int n_errors = 0;

  // behavioural reference
  int m_idx = 0;
  int m_rem = 0;
  int m_ihl = 0, m_tl = 0, m_id = 0, m_dst = 0, m_sp = 0, m_dp = 0, m_do = 0, m_pl = 0;
  int m_pkt = 0;
  string ctx = "R1";

  hdrx_top #(.LEN_W(LEN_W), .PKT_W(PKT_W)) i_hdrx_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .pay_valid(pay_valid), .ip_hdr_words(ip_hdr_words), .ip_total_len(ip_total_len),
    .ip_ident(ip_ident), .ip_dst(ip_dst), .tcp_src_port(tcp_src_port),
    .tcp_dst_port(tcp_dst_port), .tcp_doff(tcp_doff), .pay_bytes(pay_bytes),
    .pkt_num(pkt_num)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input logic v);
    string t;
    chk((v ? "R10" : "R11"), "pay_valid", longint'(pay_valid), longint'((m_idx == 11) && v));
    t = (ctx != "") ? ctx : "R3";
    chk(t, "ip_hdr_words", longint'(ip_hdr_words), longint'(m_ihl));
    chk(t, "ip_total_len", longint'(ip_total_len), longint'(m_tl));
    t = (ctx != "") ? ctx : "R4";
    chk(t, "ip_ident", longint'(ip_ident), longint'(m_id));
    t = (ctx != "") ? ctx : "R6";
    chk(t, "ip_dst", longint'(ip_dst), longint'(unsigned'(m_dst)));
    t = (ctx != "") ? ctx : "R7";
    chk(t, "tcp_src_port", longint'(tcp_src_port), longint'(m_sp));
    chk(t, "tcp_dst_port", longint'(tcp_dst_port), longint'(m_dp));
    t = (ctx != "") ? ctx : "R8";
    chk(t, "tcp_doff", longint'(tcp_doff), longint'(m_do));
    chk(t, "pay_bytes", longint'(pay_bytes), longint'(m_pl));
    t = (ctx != "") ? ctx : "R12";
    chk(t, "pkt_num", longint'(pkt_num), longint'(m_pkt % (1 << PKT_W)));
  endtask

  task automatic model(input logic v, input logic [31:0] d);
    int t;
    ctx = "";
    if (!v) begin
      ctx = "R11";
      return;
    end
    case (m_idx)
      0: if (d[31:28] == 4'd4) begin
           m_ihl = int'(d[27:24]); m_tl = int'(d[15:0]); m_idx = 1;
         end else ctx = "R2";
      1: begin m_id = int'(d[31:16]); m_idx = 2; end
      2: if (d[23:16] == 8'h06) m_idx = 3;
         else begin m_idx = 0; ctx = "R5"; end
      4: begin m_dst = int'(d); m_idx = 5; end
      6: begin m_sp = int'(d[31:16]); m_dp = int'(d[15:0]); m_idx = 7; end
      9: begin
           m_do = int'(d[31:28]);
           t = m_tl - 4*m_ihl - 4*m_do;
           m_pl = (t < 0) ? 0 : t;
           m_idx = 10;
         end
      10: begin
            ctx = "R9";
            if (m_pl == 0) begin m_pkt++; m_idx = 0; end
            else begin m_rem = m_pl; m_idx = 11; end
          end
      11: if (m_rem <= 4) begin m_pkt++; m_idx = 0; end
          else m_rem -= 4;
      default: begin ctx = "R9"; m_idx++; end
    endcase
  endtask

  task automatic step(input logic v, input logic [31:0] d);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    #1;
    compare_all(v);
    model(v, d);
  endtask

  task automatic pkt(input int ihl, input int tl, input int id, input int proto,
                     input logic [31:0] dst, input int sp, input int dp, input int doff,
                     input int nhdr, input int npay, input int stall_at);
    logic [31:0] w [$];
    w.push_back({4'd4, 4'(ihl), 8'h00, 16'(tl)});
    w.push_back({16'(id), 16'h4000});
    w.push_back({8'd64, 8'(proto), 16'hBEEF});
    w.push_back(32'hC0A8_0001);
    w.push_back(dst);
    w.push_back(32'h0101_0101);
    w.push_back({16'(sp), 16'(dp)});
    w.push_back(32'h1234_5678);
    w.push_back(32'h9ABC_DEF0);
    w.push_back({4'(doff), 12'h018, 16'hFFFF});
    w.push_back(32'h0000_0000);
    for (int i = 0; i < npay; i++) w.push_back(32'h4500_0000 + i);
    for (int i = 0; i < nhdr + npay; i++) begin
      if (i >= nhdr || i < 11) begin
        if (i == stall_at) step(1'b0, 32'h45FF_FFFF);
        step(1'b1, w[i]);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    ctx = "R1";
    compare_all(1'b0);

    // R2: bad version words dropped
    step(1'b1, 32'h6000_0050);
    step(1'b1, 32'h0500_0050);
    // normal packet, 10 payload bytes -> 3 words, stalls in header and payload (R11)
    pkt(5, 50, 16'h1111, 6, 32'h0A00_0005, 16'h0400, 16'h0050, 5, 11, 3, 4);
    step(1'b0, 32'h0);
    pkt(5, 50, 16'h1112, 6, 32'h0A00_0006, 16'h0401, 16'h0051, 5, 11, 3, 12);
    // R5: non-TCP packet abandoned after the protocol word
    pkt(5, 60, 16'h2222, 17, 32'h0, 0, 0, 5, 3, 0, -1);
    // 8 bytes exactly -> 2 words
    pkt(6, 56, 16'h3333, 6, 32'hC0A8_0A0A, 16'hABCD, 16'h0015, 6, 11, 2, -1);
    // zero payload
    pkt(5, 40, 16'h4444, 6, 32'h7F00_0001, 1, 2, 5, 11, 0, -1);
    // negative payload clamped to zero (R8)
    pkt(5, 20, 16'h5555, 6, 32'h0808_0808, 3, 4, 5, 11, 0, -1);
    // long payload: 401 bytes -> 101 words
    pkt(5, 441, 16'h6666, 6, 32'hFFFF_FFFE, 16'hFFFF, 16'h0001, 5, 11, 101, 50);
    // R12: counter wrap
    for (int k = 0; k < 255; k++)
      pkt(5, 40, k, 6, 32'(k), k, k, 5, 11, 0, -1);
    step(1'b0, 32'h0);
    step(1'b0, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule